// File: doc/BRIEF.md
# MAC Error Status and Counter Block

This block gathers error events from an Ethernet MAC and its FIFOs and turns them into an interrupt status register, an interrupt enable register, one interrupt line and four saturating error counters. Every event input is a one-cycle strobe. The block covers overrun and underrun on the FIFOs that carry receive data, receive lengths, transmit status and transmit lengths. It also covers seven kinds of receive frame error. A frame start that arrives while the receive length FIFO is full counts as a dropped frame.

Status bits come in two kinds. The receive data overrun bit and the receive frame error bits are write-one-to-clear. The six length and status FIFO overrun and underrun bits are reset-only. Writes cannot clear them, so a latched fault keeps the interrupt asserted until a device soft reset, or until software drops the matching enable bit. Software reads and writes the registers through a simple word-addressed port. Reads are combinational.

Top module: `mac_err_stat`

## Requirements
- R1: A chip reset (`rst_n` low) clears status, enable and all counters. A soft reset (`soft_rst` high at an edge) clears status and counters, keeps the enable register, and overrides any event in the same cycle.
- R2: Status bits 1..6 are reset-only. Bit 1 is receive length overrun, bit 2 receive length underrun, bit 3 transmit status overrun, bit 4 transmit status underrun, bit 5 transmit length overrun, bit 6 transmit length underrun. Writing one to them at address 0 leaves them set.
- R3: Bit 0 (receive data overrun) and bits 7..13 are cleared by writing one to them at address 0. Zero bits in the write leave their status bits unchanged.
- R4: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: `fifo_ev[i]` sets status bit i for i = 0..6. `rx_err_ev[j]` sets status bit 7+j for j = 0..6, in the order missed frame, collision, FCS, length field, short, long, alignment. The bit is visible the cycle after the strobe.
- R6: Four counters are read at addresses 2..5. Address 2 counts missed frames (status bit 7), address 3 collisions (bit 8), address 4 FCS errors (bit 9) and address 5 alignment errors (bit 13). A counter rises by one per event cycle, and writes to these addresses are ignored.
- R7: Length field, short and long errors (bits 10..12) change only status and never any counter.
- R8: When `rx_frm_start` is high while `rx_len_full` is high, the frame is dropped. This sets status bit 7 and adds one to the missed frame counter; it does not set bit 1.
- R9: Each counter stops at all ones (2^CNT_W − 1) and never wraps.
- R10: `irq` is high exactly when some status bit and its enable bit (address 1, same bit position) are both set. A set reset-only bit therefore holds `irq` until a reset or until its enable bit is written to zero.
- R11: Reads of addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| soft_rst | input | 1 | Synchronous device soft reset |
| fifo_ev | input | 7 | FIFO overrun/underrun strobes, bit i sets status bit i |
| rx_err_ev | input | 7 | Receive frame error strobes, bit j sets status bit 7+j |
| rx_frm_start | input | 1 | Start of an incoming receive frame |
| rx_len_full | input | 1 | Receive length FIFO is full |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the collisions within a single cycle. One is a strobe landing on a bit while software writes one to clear that same bit. Another is a soft reset meeting an event. A third is a frame drop meeting a missed frame strobe, which must add one to the counter, not two. Directed cycles drive each of these exactly once. A long random phase with dense strobes and frequent status writes repeats them many times over. The bench builds the block with 4-bit counters, so saturation is reached within a few dozen collision events and is also hit again and again during the random phase.

// File: rtl/mac_err_pkg.sv
package mac_err_pkg;
   localparam int ST_W  = 14;
   localparam int NCNT  = 4;
   localparam int FIFO_EV_W = 7;
   localparam int RXERR_W   = 7;

   localparam int ST_RXD_OVR = 0;
   localparam int ST_RXL_OVR = 1;
   localparam int ST_MISS    = 7;
   localparam int ST_COLL    = 8;
   localparam int ST_FCS     = 9;
   localparam int ST_ALIGN   = 13;

   // bits that only a reset can clear
   localparam logic [ST_W-1:0] STICKY_MASK = 14'b00_0000_0111_1110;

   localparam int ADR_STATUS = 0;
   localparam int ADR_ENABLE = 1;
   localparam int ADR_CNT0   = 2;
endpackage

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc && (q != TOP))
         q <= q + W'(1);
   end
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg #(
   parameter int            W      = 14,
   parameter logic [W-1:0]  STICKY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] set,
   input  logic [W-1:0] w1c,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (STICKY[i]) begin : g_reset_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (clr)    q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
         end
      end else begin : g_w1c
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (clr)    q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (w1c[i]) q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mac_err_stat.sv
module mac_err_stat
   import mac_err_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic [6:0]           fifo_ev,
   input  logic [6:0]           rx_err_ev,
   input  logic                 rx_frm_start,
   input  logic                 rx_len_full,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 irq
);
   localparam int NREG = ADR_CNT0 + NCNT;

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (DATA_W < ST_W) begin : g_bad_data_w
      $error("DATA_W too narrow for the status register");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   logic              drop;
   logic [ST_W-1:0]   ev_vec;
   logic [ST_W-1:0]   w1c;
   logic [ST_W-1:0]   status_q;
   logic [ST_W-1:0]   enable_q;
   logic [NCNT-1:0]   cnt_inc;
   logic [NCNT*CNT_W-1:0] cnt_flat;

   // frame start into a full length FIFO is dropped and counted as missed
   assign drop   = rx_frm_start & rx_len_full;
   assign ev_vec = {rx_err_ev[6:1], rx_err_ev[0] | drop, fifo_ev};
   assign w1c    = (wr_en && wr_addr == ADDR_W'(ADR_STATUS)) ? wr_data[ST_W-1:0] : '0;

   err_status_reg #(.W(ST_W), .STICKY(STICKY_MASK)) i_status (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .set   (ev_vec),
      .w1c   (w1c),
      .q     (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enable_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ADR_ENABLE))
         enable_q <= wr_data[ST_W-1:0];
   end

   assign cnt_inc = {ev_vec[ST_ALIGN], ev_vec[ST_FCS], ev_vec[ST_COLL], ev_vec[ST_MISS]};

   for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      err_sat_counter #(.W(CNT_W)) i_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (soft_rst),
         .inc   (cnt_inc[k]),
         .q     (cnt_flat[k*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_STATUS))
         rd_data = DATA_W'(status_q);
      else if (rd_addr == ADDR_W'(ADR_ENABLE))
         rd_data = DATA_W'(enable_q);
      for (int k = 0; k < NCNT; k++) begin
         if (rd_addr == ADDR_W'(ADR_CNT0 + k))
            rd_data = DATA_W'(cnt_flat[k*CNT_W +: CNT_W]);
      end
   end

   assign irq = |(status_q & enable_q);
endmodule

// File: rtl/mac_err_stat_chk.sv
module mac_err_stat_chk
   import mac_err_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   soft_rst,
   input logic [6:0]             fifo_ev,
   input logic                   rx_frm_start,
   input logic                   rx_len_full,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      wr_addr,
   input logic [ST_W-1:0]        ev_vec,
   input logic [ST_W-1:0]        status_q,
   input logic [ST_W-1:0]        enable_q,
   input logic [NCNT*CNT_W-1:0]  cnt_flat,
   input logic                   irq
);
   p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (status_q == '0 && cnt_flat == '0));

   p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> ((($past(status_q) & STICKY_MASK) & ~status_q) == '0));

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> ((status_q & $past(ev_vec)) == $past(ev_vec)));

   p_drop_no_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && rx_frm_start && rx_len_full && !fifo_ev[ST_RXL_OVR]
       && !status_q[ST_RXL_OVR]) |=> !status_q[ST_RXL_OVR]);

   p_irq_ev_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && (ev_vec & enable_q) != '0
       && !(wr_en && wr_addr == ADDR_W'(ADR_ENABLE))) |=> irq);

   for (genvar k = 0; k < NCNT; k++) begin : g_mono
      p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !soft_rst |=> (cnt_flat[k*CNT_W +: CNT_W] >= $past(cnt_flat[k*CNT_W +: CNT_W])));
   end
endmodule

bind mac_err_stat mac_err_stat_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_rst     (soft_rst),
   .fifo_ev      (fifo_ev),
   .rx_frm_start (rx_frm_start),
   .rx_len_full  (rx_len_full),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .ev_vec       (ev_vec),
   .status_q     (status_q),
   .enable_q     (enable_q),
   .cnt_flat     (cnt_flat),
   .irq          (irq)
);

// File: tb/test_mac_err_stat.sv
module test_mac_err_stat;
   localparam int CW   = 4;
   localparam int CMAX = (1 << CW) - 1;
   localparam logic [13:0] RESET_ONLY = 14'h007E; // R2 bits 1..6

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [6:0]  fifo_ev = '0;
   logic [6:0]  rx_err_ev = '0;
   logic        rx_frm_start = 1'b0;
   logic        rx_len_full = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [13:0] m_st;
   logic [13:0] m_en;
   int          m_cnt [4];

   always #5 clk = ~clk;

   mac_err_stat #(.DATA_W(32), .CNT_W(CW), .ADDR_W(3)) i_mac_err_stat (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_ev(fifo_ev),
      .rx_err_ev(rx_err_ev), .rx_frm_start(rx_frm_start), .rx_len_full(rx_len_full),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [13:0] f_ev(logic [6:0] f, logic [6:0] r, logic s, logic full);
      return {r[6:1], r[0] | (s & full), f};
   endfunction

   function automatic logic [13:0] f_next_st(logic [13:0] st, logic [13:0] ev,
                                             logic [13:0] clr, logic srst);
      if (srst) return '0;
      return (st & ~(clr & ~RESET_ONLY)) | ev;
   endfunction

   function automatic int f_sat(int v, logic inc);
      return (inc && v < CMAX) ? v + 1 : v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // one clock with the given stimulus; model updated at the edge
   task automatic cyc(logic [6:0] f, logic [6:0] r, logic s, logic full,
                      logic we, logic [2:0] wa, logic [31:0] wd, logic srst);
      logic [13:0] ev;
      logic [13:0] clr;
      fifo_ev = f; rx_err_ev = r; rx_frm_start = s; rx_len_full = full;
      wr_en = we; wr_addr = wa; wr_data = wd; soft_rst = srst;
      ev  = f_ev(f, r, s, full);
      clr = (we && wa == 3'd0) ? wd[13:0] : '0;
      @(posedge clk);
      m_st = f_next_st(m_st, ev, clr, srst);
      if (srst) begin
         for (int k = 0; k < 4; k++) m_cnt[k] = 0;
      end else begin
         m_cnt[0] = f_sat(m_cnt[0], ev[7]);
         m_cnt[1] = f_sat(m_cnt[1], ev[8]);
         m_cnt[2] = f_sat(m_cnt[2], ev[9]);
         m_cnt[3] = f_sat(m_cnt[3], ev[13]);
      end
      if (we && wa == 3'd1) m_en = wd[13:0];
      @(negedge clk);
      fifo_ev = '0; rx_err_ev = '0; rx_frm_start = 0; rx_len_full = 0;
      wr_en = 0; soft_rst = 0;
   endtask

   task automatic idle();
      cyc('0, '0, 0, 0, 0, '0, '0, 0);
   endtask

   task automatic check_all(string req);
      logic [31:0] d;
      rd(3'd0, d); chk({req, " status"}, d, {18'd0, m_st});
      rd(3'd1, d); chk({req, " enable"}, d, {18'd0, m_en});
      for (int k = 0; k < 4; k++) begin
         rd(3'(2 + k), d);
         chk({req, " R6 counter"}, d, 32'(m_cnt[k]));
      end
      chk({req, " R10 irq"}, {31'd0, irq}, {31'd0, |(m_st & m_en)});
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      m_st = '0; m_en = '0;
      for (int k = 0; k < 4; k++) m_cnt[k] = 0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R5 / R6 / R7: each event alone sets its own bit
      for (int i = 0; i < 14; i++) begin
         logic [6:0] f;
         logic [6:0] r;
         f = (i < 7) ? 7'(1 << i) : '0;
         r = (i >= 7) ? 7'(1 << (i - 7)) : '0;
         cyc(f, r, 0, 0, 0, '0, '0, 0);
         rd(3'd0, d);
         chk("R5 single event bit", d, 32'(1) << i);
         check_all("R7 counter map");
         cyc('0, '0, 0, 0, 0, '0, '0, 1);
      end

      // R2 reset-only bits ignore write-one-to-clear
      cyc(7'h7E, '0, 0, 0, 0, '0, '0, 0);
      cyc('0, '0, 0, 0, 1, 3'd0, 32'hFFFF_FFFF, 0);
      rd(3'd0, d);
      chk("R2 reset-only bits hold", d, 32'h7E);

      // R3 clearable bits
      cyc(7'h01, 7'h7F, 0, 0, 0, '0, '0, 0);
      cyc('0, '0, 0, 0, 1, 3'd0, 32'h0000_0101, 0);
      rd(3'd0, d);
      chk("R3 partial clear", d, 32'h3EFE);
      cyc('0, '0, 0, 0, 1, 3'd0, 32'hFFFF_FFFF, 0);
      rd(3'd0, d);
      chk("R3 full clear", d, 32'h7E);

      // R4 event and clear in the same cycle
      cyc('0, 7'h02, 0, 0, 1, 3'd0, 32'h0000_0100, 0);
      rd(3'd0, d);
      chk("R4 set wins", d, 32'h17E);

      // R1 soft reset beats a same-cycle event
      cyc(7'h7F, 7'h7F, 0, 0, 0, '0, '0, 1);
      rd(3'd0, d);
      chk("R1 soft reset over event", d, 32'h0);
      check_all("R1 soft reset");

      // R8 dropped frame
      cyc('0, '0, 1, 1, 0, '0, '0, 0);
      rd(3'd0, d);
      chk("R8 drop sets missed only", d, 32'h80);
      rd(3'd2, d);
      chk("R8 missed counter", d, 32'd1);
      cyc('0, 7'h01, 1, 1, 0, '0, '0, 0);
      rd(3'd2, d);
      chk("R8 drop plus missed counts once", d, 32'd2);
      cyc('0, '0, 1, 0, 0, '0, '0, 0);
      rd(3'd2, d);
      chk("R8 start without full", d, 32'd2);

      // R9 saturation
      for (int n = 0; n < CMAX + 5; n++) cyc('0, 7'h02, 0, 0, 0, '0, '0, 0);
      rd(3'd3, d);
      chk("R9 saturate", d, 32'(CMAX));
      cyc('0, 7'h02, 0, 0, 0, '0, '0, 0);
      rd(3'd3, d);
      chk("R9 no wrap", d, 32'(CMAX));

      // R6 counter write ignored, R11 unmapped reads zero
      cyc('0, '0, 0, 0, 1, 3'd3, 32'h0, 0);
      rd(3'd3, d);
      chk("R6 counter write ignored", d, 32'(CMAX));
      rd(3'd6, d); chk("R11 addr6", d, 32'h0);
      rd(3'd7, d); chk("R11 addr7", d, 32'h0);

      // R10 reset-only bit holds irq until enable cleared or reset
      cyc('0, '0, 0, 0, 0, '0, '0, 1);
      cyc('0, '0, 0, 0, 1, 3'd1, 32'h0000_0008, 0);
      chk("R10 irq idle", {31'd0, irq}, 32'd0);
      cyc(7'h08, '0, 0, 0, 0, '0, '0, 0);
      chk("R10 irq raised", {31'd0, irq}, 32'd1);
      cyc('0, '0, 0, 0, 1, 3'd0, 32'h0000_0008, 0);
      chk("R10 irq held after clear attempt", {31'd0, irq}, 32'd1);
      cyc('0, '0, 0, 0, 1, 3'd1, 32'h0, 0);
      chk("R10 irq off by enable", {31'd0, irq}, 32'd0);
      cyc('0, '0, 0, 0, 1, 3'd1, 32'h0000_0008, 0);
      chk("R10 irq back on", {31'd0, irq}, 32'd1);
      cyc('0, '0, 0, 0, 0, '0, '0, 1);
      chk("R10 irq off by reset", {31'd0, irq}, 32'd0);
      check_all("R1 enable kept");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [6:0] f;
         logic [6:0] r;
         f = 7'($urandom) & 7'($urandom) & 7'($urandom) & 7'($urandom);
         r = 7'($urandom) & 7'($urandom) & 7'($urandom);
         cyc(f, r, 1'($urandom), 1'($urandom), ($urandom % 3) == 0,
             3'($urandom), $urandom, ($urandom % 64) == 0);
         check_all("R5 random");
      end

      idle();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule